// File: doc/BRIEF.md
# Three-Port Latchable Bus Crossbar

This block routes 9-bit words between three bidirectional ports, named A, B and C. Each port feeds its own transparent input latch. Each port also has its own 2-bit source select and its own output enable. Any latched word can therefore be driven out on any port, including the port it arrived on, so that port can read its own word back as a self-check. Bit 8 of each word is treated as a parity bit. A parity-invert control flips that bit, but only when a word latched from port C is driven out on port A or port B. This lets diagnostics inject a deliberate parity error.

Each bidirectional pin is modelled as three separate buses: an input, an output and a per-bit output enable, so the block stays synthesizable. A latch is built from a clocked holding register and a bypass path. While its enable is high, the latch output follows the port input within the same cycle. When the enable goes low, the latch keeps the value that was captured at the last rising clock edge.

Top module: `xbar3_latch`

## Requirements
- R1: While the reset input is low, and until the second rising clock edge after it goes high, every output-enable bus is all zeros. At each of those edges, every latch clears to zero.
- R2: While a port's latch enable is high, that latch's output equals the current port input within the same cycle.
- R3: While a port's latch enable is low, that latch's output equals the value it captured at the last rising clock edge at which its enable was high (zero if there was none since reset).
- R4: The source-select encoding is 2'b00 = latch A, 2'b01 = latch B, 2'b10 = latch C. The selected latch output appears on that port's output bus.
- R5: Source-select code 2'b11 drives all nine output bits to zero.
- R6: A port whose select points at its own latch drives back the word that it captured itself.
- R7: With parity invert high, port A or port B selecting latch C drives bit 8 inverted, and bits 7..0 are left unchanged.
- R8: Parity invert has no effect on port C's output, and no effect on any port whose source is latch A or latch B.
- R9: Output enables are active high. When enabled, a port's 9-bit output-enable bus is all ones; otherwise it is all zeros.
- R10: The three selects, the three enables and the three latch enables act independently. All ports may route different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 9 | Port A pin input |
| b_in | input | 9 | Port B pin input |
| c_in | input | 9 | Port C pin input |
| a_le | input | 1 | Port A latch enable |
| b_le | input | 1 | Port B latch enable |
| c_le | input | 1 | Port C latch enable |
| a_oe | input | 1 | Port A output enable |
| b_oe | input | 1 | Port B output enable |
| c_oe | input | 1 | Port C output enable |
| a_sel | input | 2 | Port A source select |
| b_sel | input | 2 | Port B source select |
| c_sel | input | 2 | Port C source select |
| par_inv | input | 1 | Parity-bit invert on the C-to-A and C-to-B paths |
| a_out | output | 9 | Port A pin output |
| b_out | output | 9 | Port B pin output |
| c_out | output | 9 | Port C pin output |
| a_out_en | output | 9 | Port A per-bit drive enable |
| b_out_en | output | 9 | Port B per-bit drive enable |
| c_out_en | output | 9 | Port C per-bit drive enable |

## Verification
Two functions can act in the same cycle: latch C captures a new word transparently, while ports A and C both select it with parity invert high. The expected result is that port A shows the fresh word with bit 8 flipped, and port C shows the same word unflipped. The bench provokes this with a directed cycle and again through random stimulus. It judges every port against a behavioural model that is updated at each clock edge.

// File: rtl/xbar3_pkg.sv
package xbar3_pkg;
  typedef enum logic [1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_C    = 2'b10,
    SRC_ZERO = 2'b11
  } src_sel_e;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned PORT_C_IDX = 2;
endpackage

// File: rtl/xbar3_port_latch.sv
module xbar3_port_latch #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  logic [DW-1:0] held_q;
  logic [DW-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (le) held_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (le) held_q <= held_d;
  end

  always_comb q = le ? din : held_q;

  // R3: with the enable low on two consecutive edges, the latch output does not move
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || q == $past(q)));
endmodule

// File: rtl/xbar3_out_mux.sv
module xbar3_out_mux
  import xbar3_pkg::*;
#(
  parameter int unsigned DW = 9,
  parameter bit ALLOW_INV = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] src_c,
  input  logic [1:0]    sel,
  input  logic          par_inv,
  input  logic          oe,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] dout_en
);
  localparam int unsigned PB = DW - 1;
  logic [DW-1:0] picked;
  logic [DW-1:0] inv_mask;

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_A:   picked = src_a;
      SRC_B:   picked = src_b;
      SRC_C:   picked = src_c;
      default: picked = '0;
    endcase
  end

  generate
    if (ALLOW_INV) begin : g_inv
      always_comb begin
        inv_mask = '0;
        inv_mask[PB] = par_inv && (src_sel_e'(sel) == SRC_C);
      end
      // R7: C-sourced output has only the parity bit flipped when inversion is on
      p_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_inv && sel == 2'b10) |->
          (dout[PB] != src_c[PB] && dout[PB-1:0] == src_c[PB-1:0]));
    end else begin : g_noinv
      always_comb inv_mask = '0;
      // R8: this port never alters the C word
      p_no_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |-> (dout == src_c));
    end
  endgenerate

  always_comb begin
    dout    = picked ^ inv_mask;
    dout_en = {DW{oe & rst_n}};
  end

  // R5: the unused code yields zeros
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> (dout == '0));
endmodule

// File: rtl/xbar3_latch.sv
module xbar3_latch
  import xbar3_pkg::*;
#(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  input  logic          a_le,
  input  logic          b_le,
  input  logic          c_le,
  input  logic          a_oe,
  input  logic          b_oe,
  input  logic          c_oe,
  input  logic [1:0]    a_sel,
  input  logic [1:0]    b_sel,
  input  logic [1:0]    c_sel,
  input  logic          par_inv,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out,
  output logic [DW-1:0] c_out,
  output logic [DW-1:0] a_out_en,
  output logic [DW-1:0] b_out_en,
  output logic [DW-1:0] c_out_en
);
  logic [1:0]    sync_q;
  logic [1:0]    sync_d;
  logic          rst_sync_n;
  logic [DW-1:0] pin_in  [NUM_PORTS];
  logic          pin_le  [NUM_PORTS];
  logic          pin_oe  [NUM_PORTS];
  logic [1:0]    pin_sel [NUM_PORTS];
  logic [DW-1:0] lat_q   [NUM_PORTS];
  logic [DW-1:0] pin_out [NUM_PORTS];
  logic [DW-1:0] pin_en  [NUM_PORTS];

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb rst_sync_n = sync_q[1];

  always_comb begin
    pin_in[0] = a_in;  pin_in[1] = b_in;  pin_in[2] = c_in;
    pin_le[0] = a_le;  pin_le[1] = b_le;  pin_le[2] = c_le;
    pin_oe[0] = a_oe;  pin_oe[1] = b_oe;  pin_oe[2] = c_oe;
    pin_sel[0] = a_sel; pin_sel[1] = b_sel; pin_sel[2] = c_sel;
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      xbar3_port_latch #(.DW(DW)) u_lat (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .le   (pin_le[p]),
        .din  (pin_in[p]),
        .q    (lat_q[p])
      );
      xbar3_out_mux #(.DW(DW), .ALLOW_INV(p != PORT_C_IDX)) u_mux (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .src_a  (lat_q[0]),
        .src_b  (lat_q[1]),
        .src_c  (lat_q[2]),
        .sel    (pin_sel[p]),
        .par_inv(par_inv),
        .oe     (pin_oe[p]),
        .dout   (pin_out[p]),
        .dout_en(pin_en[p])
      );
    end
  endgenerate

  always_comb begin
    a_out = pin_out[0]; b_out = pin_out[1]; c_out = pin_out[2];
    a_out_en = pin_en[0]; b_out_en = pin_en[1]; c_out_en = pin_en[2];
  end

  // R1: no port drives while the synchronised reset is held
  always_comb begin
    if (!rst_sync_n) begin
      p_quiet_r1: assert ((a_out_en | b_out_en | c_out_en) == '0);
    end
  end

  // R6: port A reading back its own latch shows what port A fed in while transparent
  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_le && a_sel == 2'b00) |-> (a_out == a_in));
endmodule

// File: tb/xbar3_latch_bench.sv
module xbar3_latch_bench;
  localparam int DW = 9;
  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] pin [3];
  logic le [3];
  logic oe [3];
  logic [1:0] sel [3];
  logic par_inv;
  logic [DW-1:0] a_out, b_out, c_out, a_out_en, b_out_en, c_out_en;
  logic [DW-1:0] got_out [3];
  logic [DW-1:0] got_en [3];

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m_held [3];
  bit m_s0, m_s1;

  always #4 clk = ~clk;

  xbar3_latch #(.DW(DW)) u_xbar3_latch (
    .clk(clk), .rst_n(rst_n),
    .a_in(pin[0]), .b_in(pin[1]), .c_in(pin[2]),
    .a_le(le[0]), .b_le(le[1]), .c_le(le[2]),
    .a_oe(oe[0]), .b_oe(oe[1]), .c_oe(oe[2]),
    .a_sel(sel[0]), .b_sel(sel[1]), .c_sel(sel[2]),
    .par_inv(par_inv),
    .a_out(a_out), .b_out(b_out), .c_out(c_out),
    .a_out_en(a_out_en), .b_out_en(b_out_en), .c_out_en(c_out_en)
  );

  always_comb begin
    got_out[0] = a_out; got_out[1] = b_out; got_out[2] = c_out;
    got_en[0] = a_out_en; got_en[1] = b_out_en; got_en[2] = c_out_en;
  end

  function automatic logic [DW-1:0] m_lat(int s);
    if (le[s]) return pin[s];
    return (rst_n && m_s1) ? m_held[s] : '0;
  endfunction

  function automatic logic [DW-1:0] m_out(int p);
    logic [DW-1:0] v;
    case (sel[p])
      2'd0: v = m_lat(0);
      2'd1: v = m_lat(1);
      2'd2: v = m_lat(2);
      default: v = '0;
    endcase
    if (sel[p] == 2'd2 && p != 2 && par_inv) v[DW-1] = ~v[DW-1];
    return v;
  endfunction

  task automatic step(string tag);
    logic [DW-1:0] e_en;
    logic [DW-1:0] e_out;
    #3;
    for (int p = 0; p < 3; p++) begin
      e_en = (rst_n && m_s1 && oe[p]) ? '1 : '0;
      total++;
      if (got_en[p] !== e_en) begin
        bad++;
        $display("FAIL %s/R9 port %0d enable got=%h exp=%h", tag, p, got_en[p], e_en);
      end
      if (e_en != '0) begin
        e_out = m_out(p);
        total++;
        if (got_out[p] !== e_out) begin
          bad++;
          $display("FAIL %s port %0d data got=%h exp=%h", tag, p, got_out[p], e_out);
        end
      end
    end
    @(posedge clk);
    for (int s = 0; s < 3; s++) begin
      if (!rst_n || !m_s1) m_held[s] = '0;
      else if (le[s]) m_held[s] = pin[s];
    end
    if (!rst_n) begin m_s0 = 0; m_s1 = 0; end
    else begin m_s1 = m_s0; m_s0 = 1; end
    @(negedge clk);
  endtask

  task automatic set_port(int p, logic [DW-1:0] d, logic l, logic o, logic [1:0] s);
    pin[p] = d; le[p] = l; oe[p] = o; sel[p] = s;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_s0 = 0; m_s1 = 0;
    for (int s = 0; s < 3; s++) m_held[s] = '0;
    par_inv = 0;
    for (int p = 0; p < 3; p++) set_port(p, '0, 1'b0, 1'b1, 2'(p));
    rst_n = 0;
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    step("R1"); step("R1");   // reset still held inside the block
    step("R1");               // R1: latches read zero after reset
    // R2: transparency, B reads A in the same cycle
    set_port(0, 9'h1A5, 1'b1, 1'b1, 2'd1);
    set_port(1, 9'h033, 1'b0, 1'b1, 2'd0);
    step("R2");
    // R3: A closes, new input ignored
    set_port(0, 9'h0FF, 1'b0, 1'b1, 2'd1);
    step("R3"); step("R3");
    // R7 with R2: C captures while A selects C with inversion, C reads back
    par_inv = 1;
    set_port(2, 9'h0C3, 1'b1, 1'b1, 2'd2);
    set_port(0, 9'h000, 1'b0, 1'b1, 2'd2);
    set_port(1, 9'h000, 1'b0, 1'b1, 2'd2);
    step("R7");
    set_port(2, 9'h1C3, 1'b0, 1'b1, 2'd2);
    step("R8");
    // R8: inversion ignored for A and B sources
    set_port(0, 9'h000, 1'b0, 1'b1, 2'd1);
    set_port(1, 9'h000, 1'b0, 1'b1, 2'd0);
    step("R8");
    // R5: code 11
    set_port(0, 9'h000, 1'b0, 1'b1, 2'd3);
    step("R5");
    // R6: own readback
    set_port(1, 9'h15A, 1'b1, 1'b1, 2'd1);
    step("R6");
    set_port(1, 9'h000, 1'b0, 1'b1, 2'd1);
    step("R6");
    // R9: enables off
    for (int p = 0; p < 3; p++) oe[p] = 1'b0;
    step("R9");
    // R10: three different routes at once
    par_inv = 0;
    set_port(0, 9'h111, 1'b0, 1'b1, 2'd2);
    set_port(1, 9'h022, 1'b1, 1'b1, 2'd0);
    set_port(2, 9'h144, 1'b1, 1'b1, 2'd1);
    step("R10");
    // R4: random stimulus
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < 3; p++)
        set_port(p, 9'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      par_inv = 1'($urandom);
      step("R4");
    end
    // R1: reset mid-run
    rst_n = 0;
    step("R1");
    rst_n = 1;
    step("R1"); step("R1"); step("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule